// File: doc/BRIEF.md
# Perturbation-Based Gradient Step Generator

This block produces parameter corrections for on-chip learning of a recurrent fuzzy network without backpropagation. A single random perturbation vector is applied to all parameters at once. Each parameter's correction then comes from the difference between the perturbed and the unperturbed network outputs, scaled by the learning rate and the output error and divided by that parameter's own perturbation. The forward pass, the parameter store and the application of corrections all sit outside this block.

Operation has two passes, each launched by a pulse over an inclusive address range. A draw pass produces one fresh random perturbation per address. Each value goes out on a valid/ready stream so the network can add it to the parameter, and it is kept in a per-address register. An update pass takes the perturbed output, the nominal output, the desired output and the learning rate. It forms their product once, then runs a multicycle signed division for each address in the range and writes the saturated quotient to the correction memory through a plain write strobe. On the draw stream, back-pressure works like this: while `pv_valid` is high and `pv_ready` is low, the address and value hold. The random source advances only on a handshake, so a stall neither skips a value nor repeats one.

All words are 16-bit signed fixed point with 11 fraction bits, so a code of 2048 means 1.0.

Top module: `sp_grad_estimator`

## Requirements
- R1: For each address, the update pass writes q = −(η·e·d)/(c·2048), truncated toward zero. Here e = y_nom − y_des and d = y_pert − y_nom are taken at full width, η is `eta`, and all of η, e, d and c are raw signed codes. c is the perturbation held for that address.
- R2: A quotient above 32767 is written as 0x7FFF, and one below −32768 is written as 0x8000.
- R3: Every streamed perturbation has a magnitude between CMIN=2 and CMAX=20 codes inclusive (about 0.001 to 0.01) and either sign, so it is never zero.
- R4: While `pv_valid` is high and `pv_ready` is low, `pv_valid`, `pv_addr` and `pv_data` stay unchanged into the next cycle.
- R5: A draw pass offers exactly one item per address, in ascending order from `lo_addr` to `hi_addr`. If `hi_addr` < `lo_addr`, only `lo_addr` is offered.
- R6: An accepted perturbation is stored for its address and is used by every later update pass until that address is redrawn. An address never drawn since reset holds +CMIN.
- R7: The random source advances once per accepted item, so a repeated draw pass over the same range yields a different set of values.
- R8: An update pass raises `wr_en` for one cycle per address, in the same address order as R5, with `wr_addr` and `wr_data` valid in that cycle.
- R9: `pass_done` is a one-cycle pulse. For a draw pass it comes in the cycle after the last handshake. For an update pass it comes together with the last `wr_en`. In both cases `busy` is low in that cycle.
- R10: Start pulses that arrive while `busy` is high are ignored. When both starts arrive together in idle, the draw pass runs.
- R11: After reset, `busy`, `pv_valid`, `wr_en` and `pass_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gen_start | input | 1 | Launch a draw pass |
| upd_start | input | 1 | Launch an update pass |
| lo_addr | input | AW | First address of the pass |
| hi_addr | input | AW | Last address of the pass |
| eta | input | W | Learning rate, sampled at start |
| y_pert | input | W | Output with all parameters perturbed, sampled at start |
| y_nom | input | W | Unperturbed output, sampled at start |
| y_des | input | W | Desired output, sampled at start |
| pv_valid | output | 1 | Perturbation item available |
| pv_ready | input | 1 | Consumer accepts the item |
| pv_addr | output | AW | Address of the offered perturbation |
| pv_data | output | W | Offered perturbation value |
| wr_en | output | 1 | Correction write strobe |
| wr_addr | output | AW | Correction address |
| wr_data | output | W | Saturated correction |
| busy | output | 1 | A pass is in progress |
| pass_done | output | 1 | One-cycle end-of-pass pulse |

## Verification
The checker assumes three things about the environment. It starts passes only through the two start pulses, it holds no expectation on `pv_ready`, and it drives no operand in a way that depends on outputs in the same cycle. On that basis it checks the stall, range and pulse-shape properties on every cycle.

The stimulus stays within those assumptions in two ways. It changes inputs only between edges. It applies back-pressure with a fixed ready pattern and with long full stalls, so that holding and resuming are both exercised.

Operand values in the stimulus are chosen to reach zero corrections, corrections of both signs and saturation at both limits. Every value stays inside the 16-bit code range of the ports.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GEN,
    ST_MUL,
    ST_LAUNCH,
    ST_WAIT
  } sp_state_e;
endpackage

// File: rtl/sp_lfsr_pert.sv
module sp_lfsr_pert #(
  parameter int          W         = 16,
  parameter int          LFSR_W    = 16,
  parameter logic [15:0] LFSR_SEED = 16'hACE1,
  parameter logic [15:0] LFSR_TAPS = 16'hB400,
  parameter int          RAND_BITS = 8,
  parameter int          CMIN      = 2,
  parameter int          CMAX      = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                advance,
  output logic signed [W-1:0] pert
);
  localparam int SPAN = CMAX - CMIN + 1;
  localparam int SW   = RAND_BITS + W;

  logic [LFSR_W-1:0] state_q;
  logic [LFSR_W-1:0] taps;
  logic [SW-1:0]     scaled;
  logic [W-1:0]      mag;
  logic              sgn;

  assign taps = LFSR_TAPS[LFSR_W-1:0];

  // Galois form, shifting toward bit 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LFSR_SEED[LFSR_W-1:0];
    end else if (advance) begin
      state_q <= {1'b0, state_q[LFSR_W-1:1]} ^ (state_q[0] ? taps : '0);
    end
  end

  // Scale the low random bits onto [CMIN, CMAX]; sign from the top bit
  always_comb begin
    scaled = {{W{1'b0}}, state_q[RAND_BITS-1:0]} * SW'(SPAN);
    mag    = W'(CMIN) + scaled[SW-1:RAND_BITS];
    sgn    = state_q[LFSR_W-1];
    pert   = sgn ? -$signed(mag) : $signed(mag);
  end
endmodule

// File: rtl/sp_pert_bank.sv
module sp_pert_bank #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  parameter int CMIN  = 2,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [AW-1:0]       waddr,
  input  logic signed [W-1:0] wdata,
  input  logic [AW-1:0]       raddr,
  output logic signed [W-1:0] rdata
);
  logic signed [W-1:0] cell_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cell_q[g] <= W'(CMIN);
      end else if (we && (waddr == AW'(g))) begin
        cell_q[g] <= wdata;
      end
    end
  end

  assign rdata = cell_q[raddr];
endmodule

// File: rtl/sp_div_restoring.sv
module sp_div_restoring #(
  parameter int NW = 38,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          done,
  output logic [NW-1:0] quo
);
  localparam int CW = $clog2(NW + 1);

  logic [NW-1:0] q_q;
  logic [DW-1:0] r_q;
  logic [DW-1:0] d_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic [DW:0]   shifted;
  logic          fits;
  logic [DW:0]   diff;

  always_comb begin
    shifted = {r_q, q_q[NW-1]};
    fits    = shifted >= {1'b0, d_q};
    diff    = shifted - {1'b0, d_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q   <= '0;
      r_q   <= '0;
      d_q   <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        q_q   <= num;
        r_q   <= '0;
        d_q   <= den;
        cnt_q <= '0;
        run_q <= 1'b1;
      end else if (run_q) begin
        r_q   <= fits ? diff[DW-1:0] : shifted[DW-1:0];
        q_q   <= {q_q[NW-2:0], fits};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(NW - 1)) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end

  assign quo = q_q;
endmodule

// File: rtl/sp_grad_estimator.sv
module sp_grad_estimator #(
  parameter int          W         = 16,
  parameter int          FRAC      = 11,
  parameter int          DEPTH     = 16,
  parameter int          LFSR_W    = 16,
  parameter logic [15:0] LFSR_SEED = 16'hACE1,
  parameter logic [15:0] LFSR_TAPS = 16'hB400,
  parameter int          RAND_BITS = 8,
  parameter int          CMIN      = 2,
  parameter int          CMAX      = 20,
  localparam int         AW        = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gen_start,
  input  logic          upd_start,
  input  logic [AW-1:0] lo_addr,
  input  logic [AW-1:0] hi_addr,
  input  logic [W-1:0]  eta,
  input  logic [W-1:0]  y_pert,
  input  logic [W-1:0]  y_nom,
  input  logic [W-1:0]  y_des,
  output logic          pv_valid,
  input  logic          pv_ready,
  output logic [AW-1:0] pv_addr,
  output logic [W-1:0]  pv_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [W-1:0]  wr_data,
  output logic          busy,
  output logic          pass_done
);
  import sp_pkg::*;

  localparam int PW   = 3 * W + 2;          // eta * (W+1) * (W+1)
  localparam int NUMW = PW - 1 - FRAC;      // magnitude after fraction drop
  localparam logic [NUMW-1:0] QPOS = NUMW'((64'd1 << (W - 1)) - 64'd1);

  sp_state_e state_q;
  logic [AW-1:0]        cur_q, hi_q;
  logic signed [W-1:0]  eta_q, yp_q, yn_q, yd_q;
  logic signed [PW-1:0] prod_q;
  logic                 neg_q;
  logic                 last;
  logic                 accept;

  logic signed [W-1:0]  pert;
  logic signed [W-1:0]  c_cur;
  logic signed [PW-1:0] eta_x, err_x, dif_x, prod_c;
  logic [PW-1:0]        prod_mag;
  logic [W-1:0]         c_mag;
  logic                 div_start, div_done;
  logic [NUMW-1:0]      quo;
  logic [W-1:0]         sat_val;

  assign last     = cur_q >= hi_q;
  assign pv_valid = (state_q == ST_GEN);
  assign pv_addr  = cur_q;
  assign pv_data  = pert;
  assign accept   = pv_valid && pv_ready;
  assign busy     = (state_q != ST_IDLE);
  assign div_start = (state_q == ST_LAUNCH);

  sp_lfsr_pert #(
    .W(W), .LFSR_W(LFSR_W), .LFSR_SEED(LFSR_SEED), .LFSR_TAPS(LFSR_TAPS),
    .RAND_BITS(RAND_BITS), .CMIN(CMIN), .CMAX(CMAX)
  ) u_rng (
    .clk(clk), .rst_n(rst_n), .advance(accept), .pert(pert)
  );

  sp_pert_bank #(.W(W), .DEPTH(DEPTH), .CMIN(CMIN)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(accept), .waddr(cur_q), .wdata(pert),
    .raddr(cur_q), .rdata(c_cur)
  );

  // Shared numerator: eta * e * d, formed once per update pass
  always_comb begin
    eta_x  = {{(PW - W){eta_q[W-1]}}, eta_q};
    err_x  = {{(PW - W){yn_q[W-1]}}, yn_q} - {{(PW - W){yd_q[W-1]}}, yd_q};
    dif_x  = {{(PW - W){yp_q[W-1]}}, yp_q} - {{(PW - W){yn_q[W-1]}}, yn_q};
    prod_c = eta_x * err_x * dif_x;
  end

  always_comb begin
    prod_mag = prod_q[PW-1] ? PW'(-prod_q) : PW'(prod_q);
    c_mag    = c_cur[W-1] ? W'(-c_cur) : W'(c_cur);
  end

  sp_div_restoring #(.NW(NUMW), .DW(W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start),
    .num(prod_mag[PW-2:FRAC]), .den(c_mag),
    .done(div_done), .quo(quo)
  );

  // Sign apply and clamp to the signed word range
  always_comb begin
    if (neg_q) begin
      sat_val = (quo > QPOS) ? {1'b1, {(W-1){1'b0}}} : W'(-quo[W-1:0]);
    end else begin
      sat_val = (quo > QPOS) ? {1'b0, {(W-1){1'b1}}} : quo[W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cur_q     <= '0;
      hi_q      <= '0;
      eta_q     <= '0;
      yp_q      <= '0;
      yn_q      <= '0;
      yd_q      <= '0;
      prod_q    <= '0;
      neg_q     <= 1'b0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      pass_done <= 1'b0;
    end else begin
      wr_en     <= 1'b0;
      pass_done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (gen_start) begin
            cur_q   <= lo_addr;
            hi_q    <= hi_addr;
            state_q <= ST_GEN;
          end else if (upd_start) begin
            cur_q   <= lo_addr;
            hi_q    <= hi_addr;
            eta_q   <= eta;
            yp_q    <= y_pert;
            yn_q    <= y_nom;
            yd_q    <= y_des;
            state_q <= ST_MUL;
          end
        end
        ST_GEN: begin
          if (accept) begin
            if (last) begin
              state_q   <= ST_IDLE;
              pass_done <= 1'b1;
            end else begin
              cur_q <= cur_q + 1'b1;
            end
          end
        end
        ST_MUL: begin
          prod_q  <= prod_c;
          state_q <= ST_LAUNCH;
        end
        ST_LAUNCH: begin
          // result is negative when product and perturbation share a sign
          neg_q   <= (prod_q[PW-1] == c_cur[W-1]);
          state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (div_done) begin
            wr_en   <= 1'b1;
            wr_addr <= cur_q;
            wr_data <= sat_val;
            if (last) begin
              state_q   <= ST_IDLE;
              pass_done <= 1'b1;
            end else begin
              cur_q   <= cur_q + 1'b1;
              state_q <= ST_LAUNCH;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sp_grad_estimator_chk.sv
module sp_grad_estimator_chk #(
  parameter int W    = 16,
  parameter int AW   = 4,
  parameter int CMIN = 2,
  parameter int CMAX = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pv_valid,
  input logic          pv_ready,
  input logic [AW-1:0] pv_addr,
  input logic [W-1:0]  pv_data,
  input logic          wr_en,
  input logic          busy,
  input logic          pass_done
);
  logic [W-1:0] mag;
  assign mag = pv_data[W-1] ? W'(-pv_data) : pv_data;

  a_r3_pert_in_band: assert property (@(posedge clk) disable iff (!rst_n)
    pv_valid |-> (mag >= W'(CMIN)) && (mag <= W'(CMAX)));

  a_r4_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pv_valid && !pv_ready) |=> pv_valid && $stable(pv_data) && $stable(pv_addr));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    pass_done |=> !pass_done);

  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    pass_done |-> !busy);

  a_r8_no_mixed_pass: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pv_valid, wr_en}));

  a_r10_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> !wr_en && !pv_valid);
endmodule

bind sp_grad_estimator sp_grad_estimator_chk #(
  .W(W), .AW(AW), .CMIN(CMIN), .CMAX(CMAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pv_valid(pv_valid), .pv_ready(pv_ready),
  .pv_addr(pv_addr), .pv_data(pv_data), .wr_en(wr_en), .busy(busy),
  .pass_done(pass_done)
);

// File: tb/tb_sp_grad_estimator.sv
module tb_sp_grad_estimator;
  localparam int W = 16;
  localparam int DEPTH = 16;
  localparam int AW = 4;
  localparam int CMIN = 2;
  localparam int CMAX = 20;

  logic clk = 0, rst_n = 0;
  logic gen_start = 0, upd_start = 0, pv_ready = 0;
  logic [AW-1:0] lo_addr = '0, hi_addr = '0;
  logic [W-1:0] eta = '0, y_pert = '0, y_nom = '0, y_des = '0;
  logic pv_valid, wr_en, busy, pass_done;
  logic [AW-1:0] pv_addr, wr_addr;
  logic [W-1:0] pv_data, wr_data;

  int vectors = 0, fails = 0;
  int pert_seen [DEPTH];
  bit finished = 0;

  always #5 clk = ~clk;

  sp_grad_estimator dut (
    .clk(clk), .rst_n(rst_n), .gen_start(gen_start), .upd_start(upd_start),
    .lo_addr(lo_addr), .hi_addr(hi_addr), .eta(eta), .y_pert(y_pert),
    .y_nom(y_nom), .y_des(y_des), .pv_valid(pv_valid), .pv_ready(pv_ready),
    .pv_addr(pv_addr), .pv_data(pv_data), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .pass_done(pass_done)
  );

  task automatic chk(bit ok, string req, longint act, longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_delta(int e_t, int yp, int yn, int yd, int c);
    longint p, q;
    p = longint'(e_t) * longint'(yn - yd) * longint'(yp - yn);
    q = -p / (longint'(c) * 2048);
    if (q > 32767) q = 32767;
    if (q < -32768) q = -32768;
    return int'(q);
  endfunction

  task automatic run_gen(int lo, int hi, int pat, output int got);
    int exp_a, pd;
    bit stall;
    @(negedge clk);
    lo_addr = AW'(lo); hi_addr = AW'(hi); gen_start = 1;
    @(negedge clk);
    gen_start = 0;
    got = 0; exp_a = lo; stall = 0; pd = 0;
    for (int cyc = 0; cyc < 2000; cyc++) begin
      pv_ready = (pat == 0) ? 1'b1 : (cyc % 3 != 0);
      if (stall) chk(pv_valid && (int'($signed(pv_data)) == pd), "R4 hold", $signed(pv_data), pd);
      if (pv_valid && pv_ready) begin
        int d;
        d = int'($signed(pv_data));
        chk(int'(pv_addr) == exp_a, "R5 order", pv_addr, exp_a);
        chk((d != 0) && ((d < 0 ? -d : d) >= CMIN) && ((d < 0 ? -d : d) <= CMAX), "R3 band", d, CMIN);
        pert_seen[pv_addr] = d;
        got++; exp_a++;
      end
      stall = pv_valid && !pv_ready;
      pd = int'($signed(pv_data));
      @(negedge clk);
      if (pass_done) begin
        chk(!busy, "R9 idle at done", busy, 0);
        break;
      end
    end
    pv_ready = 0;
  endtask

  task automatic run_upd(int lo, int hi, int e_t, int yp, int yn, int yd, string req, output int got);
    int exp_a;
    @(negedge clk);
    lo_addr = AW'(lo); hi_addr = AW'(hi);
    eta = W'(e_t); y_pert = W'(yp); y_nom = W'(yn); y_des = W'(yd);
    upd_start = 1;
    @(negedge clk);
    upd_start = 0;
    got = 0; exp_a = lo;
    for (int cyc = 0; cyc < 5000; cyc++) begin
      if (wr_en) begin
        int ev;
        ev = exp_delta(e_t, yp, yn, yd, pert_seen[wr_addr]);
        chk(int'(wr_addr) == exp_a, "R8 order", wr_addr, exp_a);
        chk(int'($signed(wr_data)) == ev, req, $signed(wr_data), ev);
        got++; exp_a++;
      end
      if (pass_done) begin
        chk(wr_en && !busy, "R9 done with last write", wr_en, 1);
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !pv_valid && !wr_en && !pass_done, "R11 reset outputs",
        {busy, pv_valid, wr_en, pass_done}, 0);
    rst_n = 1;
  endtask

  task automatic t_reset_pert();
    int n;
    run_upd(8, 8, 2048, 1030, 1024, 0, "R6 reset perturbation", n);
    chk(n == 1, "R6 count", n, 1);
  endtask

  task automatic t_basic();
    int n;
    run_gen(0, 3, 0, n);
    chk(n == 4, "R5 count", n, 4);
    run_upd(0, 3, 2048, 1030, 1024, 0, "R1 positive error", n);
    chk(n == 4, "R8 count", n, 4);
  endtask

  task automatic t_backpressure();
    int n;
    run_gen(4, 7, 1, n);
    chk(n == 4, "R4 count under stall", n, 4);
    run_upd(4, 7, 100, -480, -500, 300, "R1 negative error", n);
    chk(n == 4, "R8 count", n, 4);
  endtask

  task automatic t_zero_and_sat();
    int n;
    run_upd(0, 7, 2048, 900, 700, 700, "R1 zero error", n);
    chk(n == 8, "R8 count", n, 8);
    run_upd(0, 7, 32767, -16000, 16000, -16000, "R2 saturation", n);
    chk(n == 8, "R8 count", n, 8);
  endtask

  task automatic t_reversed();
    int n;
    run_gen(10, 9, 0, n);
    chk(n == 1, "R5 reversed range", n, 1);
  endtask

  task automatic t_fresh();
    int n, old [4];
    bit diff;
    for (int i = 0; i < 4; i++) old[i] = pert_seen[i];
    run_gen(0, 3, 0, n);
    diff = 0;
    for (int i = 0; i < 4; i++) if (old[i] != pert_seen[i]) diff = 1;
    chk(diff, "R7 fresh draw", diff, 1);
    run_upd(0, 7, 300, 2100, 2000, 1000, "R6 retained values", n);
    chk(n == 8, "R8 count", n, 8);
  endtask

  task automatic t_busy_ignore();
    int n, extra;
    @(negedge clk);
    lo_addr = 4'd5; hi_addr = 4'd6; gen_start = 1; upd_start = 1;
    @(negedge clk);
    gen_start = 0; upd_start = 0;
    chk(pv_valid && busy, "R10 draw wins", pv_valid, 1);
    extra = 0;
    for (int i = 0; i < 6; i++) begin
      lo_addr = 4'd0; hi_addr = 4'd15; upd_start = 1; gen_start = (i % 2 == 0);
      @(negedge clk);
      if (wr_en) extra++;
    end
    upd_start = 0; gen_start = 0;
    n = 0;
    for (int i = 0; i < 20; i++) begin
      pv_ready = 1;
      if (pv_valid) begin
        chk(int'(pv_addr) == 5 + n, "R10 original range kept", pv_addr, 5 + n);
        pert_seen[pv_addr] = int'($signed(pv_data));
        n++;
      end
      @(negedge clk);
      if (pass_done) break;
    end
    pv_ready = 0;
    chk(n == 2, "R10 item count", n, 2);
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (wr_en || pv_valid || busy) extra++;
    end
    chk(extra == 0, "R10 starts ignored", extra, 0);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) pert_seen[i] = CMIN;
    t_reset();
    t_reset_pert();
    t_basic();
    t_backpressure();
    t_zero_and_sat();
    t_reversed();
    t_fresh();
    t_busy_ignore();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      vectors++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule